// File: doc/BRIEF.md
# Serial Word Scrambler with NRZI Line Coding

This block turns a stream of fixed-width parallel words into one serial bit per clock for a high-rate video link. An internal word counter asks for a new word once every `WORD_W` serial clocks. The captured word is shifted out, least significant bit first by default. Each serial bit passes through a self-synchronising scrambler built on the generator x^9 + x^4 + 1. The scrambled bit is then line-coded with the differential x + 1 rule, so every scrambled one becomes a level change on the line.

The serial clock is expected to run at `WORD_W` times the word rate. The surrounding logic drives the next word whenever the load request is high.

The `bypass` input sends the raw serialised bits to the line for data that is already scrambled or already carries its own code, such as 8b/10b. While `bypass` is high, the scrambler history and the line level are frozen. The `clr` input clears the scrambler history, the line level and the word counter.

Top module: `scram_nrzi_ser`

## Requirements
- R1: While `clr` is high at a rising edge, every state element is cleared. After that edge `sdo` is 0, and it stays 0 until the first bit of the first word captured after `clr` falls arrives.
- R2: `load_o` is high in the cycle after a `clr` edge. It is then high for exactly one cycle in every `WORD_W` cycles. `word_in` is captured at the rising edge that ends a cycle in which `load_o` is high.
- R3: With the default order, bit k of a captured word (k = 0 is the LSB) is the serial bit for the k-th edge after the capture edge. It reaches `sdo` one edge later.
- R4: With `bypass` low, the scrambled bit is y[n] = d[n] XOR y[n-4] XOR y[n-9], where y is the history of scrambled bits and that history is all zeros after `clr`.
- R5: With `bypass` low, `sdo` changes level after an edge exactly when the scrambled bit consumed at that edge is 1. The line level is 0 after `clr`.
- R6: With `bypass` high, `sdo` equals the raw serial bit, with the same one-edge delay that the coded path has.
- R7: At edges where `bypass` is high, the scrambler history and the line level hold their values. Coding resumes from the held state when `bypass` falls.
- R8: Descrambling `sdo` recovers the original bit stream exactly. The descrambler takes y = sdo XOR previous sdo, then d = y XOR y[n-4] XOR y[n-9], starting from the cleared state.
- R9: With the order parameter set to MSB first, bit (WORD_W-1-k) of the word takes the place of bit k in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, WORD_W times the word rate |
| clr | input | 1 | Synchronous active-high clear of scrambler, line coder and word counter |
| bypass | input | 1 | High: raw serial bits go to the line and coder state is frozen |
| word_in | input | WORD_W | Parallel word, sampled at the edge that ends a load cycle |
| load_o | output | 1 | High in the cycle whose closing edge captures `word_in` |
| sdo | output | 1 | Serial line output |

## Verification
A word presented while `load_o` is high is captured at the next rising edge. Its bit k reaches `sdo` after k+1 further edges, so the bench samples it at the falling edge k+2 cycles after the load cycle. The output multiplexer follows `bypass` combinationally. For that reason the bench changes `bypass` only at a falling edge, after it has sampled `sdo`. The bench keeps its own queue of sent bits, its own scrambler and line model, and an independent descrambler fed only from `sdo`. Every falling edge is compared against these, using exactly that delay.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef enum logic {ORDER_LSB = 1'b0, ORDER_MSB = 1'b1} bit_order_e;
   localparam int DEF_WORD_W   = 10;
   localparam int DEF_TAP_NEAR = 4;
   localparam int DEF_TAP_FAR  = 9;
endpackage

// File: rtl/word_shifter.sv
module word_shifter
   import scr_pkg::*;
#(
   parameter int         W     = DEF_WORD_W,
   parameter bit_order_e ORDER = ORDER_LSB
) (
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] word_i,
   output logic         load_o,
   output logic         bit_o
);
   localparam int          CW   = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   if (W < 2) begin : g_bad_width
      $error("word_shifter: W must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  sh_q;

   assign load_o = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (clr)         cnt_q <= LAST;
      else if (load_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   if (ORDER == ORDER_LSB) begin : g_lsb
      always_ff @(posedge clk) begin
         if (clr)         sh_q <= '0;
         else if (load_o) sh_q <= word_i;
         else             sh_q <= {1'b0, sh_q[W-1:1]};
      end
      assign bit_o = sh_q[0];

      // R3
      lsb_first_chk: assert property (@(posedge clk) disable iff (clr)
         load_o |=> (bit_o == $past(word_i[0])));
   end else begin : g_msb
      always_ff @(posedge clk) begin
         if (clr)         sh_q <= '0;
         else if (load_o) sh_q <= word_i;
         else             sh_q <= {sh_q[W-2:0], 1'b0};
      end
      assign bit_o = sh_q[W-1];

      // R9
      msb_first_chk: assert property (@(posedge clk) disable iff (clr)
         load_o |=> (bit_o == $past(word_i[W-1])));
   end

   // R2
   load_single_chk: assert property (@(posedge clk) disable iff (clr)
      load_o |=> !load_o);
endmodule

// File: rtl/lfsr_scrambler.sv
module lfsr_scrambler
   import scr_pkg::*;
#(
   parameter int NEAR = DEF_TAP_NEAR,
   parameter int FAR  = DEF_TAP_FAR
) (
   input  logic clk,
   input  logic clr,
   input  logic en,
   input  logic d_i,
   output logic y_o
);
   if (NEAR < 1 || NEAR >= FAR) begin : g_bad_taps
      $error("lfsr_scrambler: need 1 <= NEAR < FAR");
   end

   // hist_q[0] is the most recent scrambled bit
   logic [FAR-1:0] hist_q;

   assign y_o = d_i ^ hist_q[NEAR-1] ^ hist_q[FAR-1];

   always_ff @(posedge clk) begin
      if (clr)     hist_q <= '0;
      else if (en) hist_q <= {hist_q[FAR-2:0], y_o};
   end

   // R4
   hist_shift_chk: assert property (@(posedge clk) disable iff (clr)
      en |=> (hist_q[FAR-1:1] == $past(hist_q[FAR-2:0])));

   // R7
   hist_hold_chk: assert property (@(posedge clk) disable iff (clr)
      !en |=> $stable(hist_q));
endmodule

// File: rtl/nrzi_encoder.sv
module nrzi_encoder (
   input  logic clk,
   input  logic clr,
   input  logic en,
   input  logic y_i,
   output logic lvl_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (clr)     lvl_q <= 1'b0;
      else if (en) lvl_q <= lvl_q ^ y_i;
   end

   assign lvl_o = lvl_q;

   // R7
   level_hold_chk: assert property (@(posedge clk) disable iff (clr)
      !en |=> $stable(lvl_q));
endmodule

// File: rtl/scram_nrzi_ser.sv
module scram_nrzi_ser
   import scr_pkg::*;
#(
   parameter int         WORD_W   = DEF_WORD_W,
   parameter int         TAP_NEAR = DEF_TAP_NEAR,
   parameter int         TAP_FAR  = DEF_TAP_FAR,
   parameter bit_order_e ORDER    = ORDER_LSB
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              bypass,
   input  logic [WORD_W-1:0] word_in,
   output logic              load_o,
   output logic              sdo
);
   logic ser_bit;
   logic scr_bit;
   logic line_lvl;
   logic raw_q;
   logic code_en;

   assign code_en = ~bypass;

   word_shifter #(.W(WORD_W), .ORDER(ORDER)) u_shift (
      .clk    (clk),
      .clr    (clr),
      .word_i (word_in),
      .load_o (load_o),
      .bit_o  (ser_bit)
   );

   lfsr_scrambler #(.NEAR(TAP_NEAR), .FAR(TAP_FAR)) u_scr (
      .clk (clk),
      .clr (clr),
      .en  (code_en),
      .d_i (ser_bit),
      .y_o (scr_bit)
   );

   nrzi_encoder u_nrzi (
      .clk   (clk),
      .clr   (clr),
      .en    (code_en),
      .y_i   (scr_bit),
      .lvl_o (line_lvl)
   );

   always_ff @(posedge clk) begin
      if (clr) raw_q <= 1'b0;
      else     raw_q <= ser_bit;
   end

   assign sdo = bypass ? raw_q : line_lvl;

   // R6
   bypass_path_chk: assert property (@(posedge clk) disable iff (clr)
      bypass |=> (bypass == 1'b0 || sdo == $past(ser_bit)));

   // R5
   line_toggle_chk: assert property (@(posedge clk) disable iff (clr)
      !bypass |=> (bypass == 1'b1 || ((sdo ^ $past(sdo)) == $past(scr_bit))));
endmodule

// File: tb/scram_nrzi_ser_bench.sv
module scram_nrzi_ser_bench;
   import scr_pkg::*;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         clr = 1'b1;
   logic         bypass = 1'b1;
   logic [W-1:0] word_in = '0;
   logic         load_o, sdo, load_m, sdo_m;

   always #10 clk = ~clk;

   scram_nrzi_ser #(.WORD_W(W)) u_scram_nrzi_ser (
      .clk(clk), .clr(clr), .bypass(bypass), .word_in(word_in),
      .load_o(load_o), .sdo(sdo));

   scram_nrzi_ser #(.WORD_W(W), .ORDER(ORDER_MSB)) u_scram_nrzi_ser_msb (
      .clk(clk), .clr(clr), .bypass(1'b1), .word_in(word_in),
      .load_o(load_m), .sdo(sdo_m));

   int total = 0;
   int bad = 0;
   bit lsb_bits[64];
   bit msb_bits[64];
   int wr = 0, rd = 0, age = -1, ph = 0;
   int mode = 0, seq = 0;
   logic [8:0] mh = '0, dh = '0;
   logic mn = 1'b0, dprev = 1'b0;
   string tag_scr = "R4,R5";

   task automatic check(string tag, logic act, logic exp_v);
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp_v, $time);
      end
   endtask

   function automatic logic [W-1:0] gen_word(int m, int s);
      logic [W-1:0] w;
      case (m)
         0: case (s % 6)
               0: w = 10'h001;
               1: w = 10'h200;
               2: w = 10'h155;
               3: w = 10'h2AA;
               4: w = 10'h3FF;
               default: w = 10'h000;
            endcase
         1: w = W'(s);
         2: w = W'(s * 37 + 11);
         default: w = '0;
      endcase
      return w;
   endfunction

   // Called at a falling edge: check outputs, then drive inputs for the next rising edge.
   task automatic step(bit clr_next, bit byp_next);
      logic [W-1:0] w;
      check("R2", load_o, (ph == 0));
      check("R2", load_m, (ph == 0));
      if (age >= 1 && rd < wr) begin
         bit d, dm, y, yr, dr;
         d  = lsb_bits[rd % 64];
         dm = msb_bits[rd % 64];
         rd++;
         check("R9", sdo_m, dm);
         if (bypass) begin
            check("R3,R6", sdo, d);
         end else begin
            y  = d ^ mh[3] ^ mh[8];
            mh = {mh[7:0], y};
            mn = mn ^ y;
            check(tag_scr, sdo, mn);
            yr = sdo ^ dprev;
            dr = yr ^ dh[3] ^ dh[8];
            dh = {dh[7:0], yr};
            dprev = sdo;
            check("R8", dr, d);
         end
      end else begin
         check("R1", sdo, 1'b0);
      end
      clr    = clr_next;
      bypass = byp_next;
      if (clr_next) begin
         wr = 0; rd = 0; age = -1; ph = 0;
         mh = '0; mn = 1'b0; dh = '0; dprev = 1'b0;
      end else begin
         if (age >= 0) age++;
         if (ph == 0) begin
            w = gen_word(mode, seq);
            seq++;
            word_in = w;
            for (int k = 0; k < W; k++) begin
               lsb_bits[(wr + k) % 64] = w[k];
               msb_bits[(wr + k) % 64] = w[W-1-k];
            end
            wr += W;
            if (age < 0) age = 0;
         end
         ph = (ph + 1) % W;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // bypass, directed words: order and raw path
      mode = 0; seq = 0;
      step(1'b1, 1'b1);
      repeat (70) step(1'b0, 1'b1);
      // exhaustive sweep of all words through scrambler and line coder
      step(1'b1, 1'b0);
      mode = 1; seq = 0; tag_scr = "R4,R5";
      repeat (W * 1024 + 5) step(1'b0, 1'b0);
      // bypass toggling mid-stream, coder state must hold
      mode = 2; seq = 0; tag_scr = "R7";
      for (int i = 0; i < 400; i++) step(1'b0, ((i / 7) % 2) == 1);
      // clear in the middle of a word, then all-zero words
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      mode = 3; seq = 0; tag_scr = "R1,R4";
      repeat (40) step(1'b0, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule